// File: doc/BRIEF.md
# Interleaved Vectorized Sum Reduction

This block adds up a stream of integers of any length and returns one scalar total. A start pulse carries the element count. Input vectors of `VEC` lanes then arrive over a valid/ready handshake, which is normally fed from a FIFO that may stall. Each lane has an adder that takes `LAT` cycles to write its result back. A single running total per lane would therefore accept one beat only every `LAT` cycles.

To avoid that stall, the block keeps `VEC × LAT` partial sums. Successive accepted beats rotate through `LAT` partial-sum rows, so a row is read again only after its previous update has landed, and the block takes one full vector every clock. After the last beat, the block waits for the lane pipelines to empty. It then folds all partial sums into one accumulator through a scalar adder with the same `LAT`-cycle latency, and holds the total on a result handshake until it is taken. The adders are wrap-around integer adders of width `W`.

Top module: `vsum_reduce`

## Requirements
- R1: After reset, `busy`, `in_ready` and `res_valid` are low.
- R2: A `start` pulse is taken only while `busy` is low. It loads `len`, clears every partial sum and raises `busy` on the next cycle. A `start` seen while `busy` is high has no effect on the run in progress or on its result.
- R3: `in_ready` is high only while accepted beats still owe elements. Once the count is used up it stays low. With `in_valid` held high, one beat is taken in every cycle, with no gaps.
- R4: A cycle without an accepted beat changes no partial sum and does not move the row pointer.
- R5: Each accepted beat consumes up to `VEC` elements. Lane i sits in `in_data[i*W +: W]`. In the final beat, lanes at or beyond the remaining count are treated as zero whatever they carry.
- R6: `res_sum` equals the sum, modulo 2^W, of the first `len` elements taken. A length of 0 gives 0.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_sum` hold steady. A cycle with both high returns the block to idle, with `busy` and `res_valid` low.
- R8: `res_valid` rises exactly `LAT*(VEC*LAT+1)+1` clock edges after the edge that accepted the last beat. For a zero length it rises `VEC*LAT*LAT+3` edges after the edge that accepted `start`.
- R9: Each accepted beat adds into partial-sum row `k`, and `k` steps from 0 up to `LAT-1` and back to 0 on accepted beats only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reduction; taken only when idle |
| len | input | CW | Element count for the run, latched on start |
| busy | output | 1 | High from an accepted start until the result is taken |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block will take the beat on this edge |
| in_data | input | VEC*W | Lane i at bits [i*W +: W] |
| res_valid | output | 1 | Total is available |
| res_ready | input | 1 | Consumer takes the total |
| res_sum | output | W | Total modulo 2^W |

## Verification
With `VEC=4` and `LAT=3`, the total is due 40 edges after the last accepted beat, or 39 edges after `start` for an empty run. The bench records the edge on which each handshake completes, by sampling at the falling edge while the next rising edge is pending. It then compares the edge on which `res_valid` is first seen against that formula. Lengths 0 to 41 are swept twice: once with back-to-back input, and once with random input gaps, a random result back-pressure of up to three cycles, and stray start pulses during the run. A long random run follows. Each total is checked against a sum formed in the bench that skips the unused lanes of the final beat.

// File: rtl/vsum_reduce.sv
module vsum_reduce #(
  parameter int VEC = 4,
  parameter int LAT = 3,
  parameter int W   = 32,
  parameter int CW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CW-1:0]      len,
  output logic               busy,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [VEC*W-1:0]   in_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [W-1:0]       res_sum
);
  localparam int N  = VEC * LAT;
  localparam int D  = LAT - 1;
  localparam int IW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam int AW = (N > 1) ? $clog2(N) : 1;
  localparam int MW = $clog2(N + 1);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_DRAIN, S_MERGE, S_DONE} st_t;

  st_t            st;
  logic [CW-1:0]  rem;
  logic [IW-1:0]  idx;
  logic [W-1:0]   bank [N];
  logic [W-1:0]   pd   [D][VEC];
  logic [IW-1:0]  pt   [D];
  logic [D-1:0]   pv;
  logic [W-1:0]   sp   [D];
  logic [D-1:0]   sv;
  logic [W-1:0]   acc;
  logic [MW-1:0]  mi;
  logic [W-1:0]   op   [VEC];
  logic [W-1:0]   mrd;
  logic [CW-1:0]  take;
  logic           fire, issue, go;

  function automatic logic [AW-1:0] slot(input logic [IW-1:0] r, input int l);
    return AW'(int'(r) * VEC + l);
  endfunction

  assign busy      = (st != S_IDLE);
  assign in_ready  = (st == S_RUN) && (rem != '0);
  assign res_valid = (st == S_DONE);
  assign res_sum   = acc;
  assign fire      = in_valid && in_ready;
  assign go        = start && (st == S_IDLE);
  assign take      = (rem > CW'(VEC)) ? CW'(VEC) : rem;
  assign issue     = (st == S_MERGE) && !(|sv) && (mi != MW'(N));
  assign mrd       = (mi < MW'(N)) ? bank[AW'(mi)] : '0;

  always_comb
    for (int i = 0; i < VEC; i++)
      op[i] = (CW'(i) < rem) ? in_data[i*W +: W] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      rem <= '0;
      idx <= '0;
      mi  <= '0;
    end else begin
      case (st)
        S_IDLE:  if (start) begin
                   rem <= len;
                   idx <= '0;
                   st  <= S_RUN;
                 end
        S_RUN:   begin
                   if (fire) begin
                     rem <= rem - take;
                     idx <= (idx == IW'(LAT - 1)) ? '0 : idx + 1'b1;
                   end
                   if (rem == '0) st <= S_DRAIN;
                 end
        S_DRAIN: if (!(|pv)) begin
                   mi <= '0;
                   st <= S_MERGE;
                 end
        S_MERGE: begin
                   if (issue) mi <= mi + 1'b1;
                   if (!(|sv) && mi == MW'(N)) st <= S_DONE;
                 end
        S_DONE:  if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      sv <= '0;
      for (int k = 0; k < D; k++) begin
        pt[k] <= '0;
        sp[k] <= '0;
        for (int i = 0; i < VEC; i++) pd[k][i] <= '0;
      end
    end else begin
      pv[0] <= fire;
      pt[0] <= idx;
      for (int i = 0; i < VEC; i++) pd[0][i] <= bank[slot(idx, i)] + op[i];
      sv[0] <= issue;
      sp[0] <= acc + mrd;
      for (int k = 1; k < D; k++) begin
        pv[k] <= pv[k-1];
        pt[k] <= pt[k-1];
        sv[k] <= sv[k-1];
        sp[k] <= sp[k-1];
        for (int i = 0; i < VEC; i++) pd[k][i] <= pd[k-1][i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) bank[j] <= '0;
    end else if (go) begin
      for (int j = 0; j < N; j++) bank[j] <= '0;
    end else if (pv[D-1]) begin
      for (int i = 0; i < VEC; i++) bank[slot(pt[D-1], i)] <= pd[D-1][i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        acc <= '0;
    else if (st == S_DRAIN && !(|pv))  acc <= '0;
    else if (sv[D-1])                  acc <= sp[D-1];
  end

  initial if (LAT < 2) $error("vsum_reduce needs LAT of at least 2");
endmodule

// File: rtl/vsum_reduce_chk.sv
module vsum_reduce_chk #(
  parameter int LAT = 3,
  parameter int W   = 32,
  parameter int CW  = 16,
  parameter int IW  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          in_valid,
  input logic          in_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [W-1:0]  res_sum,
  input logic [IW-1:0] idx,
  input logic [CW-1:0] rem
);
  AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy && !res_valid); // R3
  AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> rem < $past(rem)); // R3
  AST_STALL_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(in_valid && in_ready)) |=> $stable(idx)); // R4
  AST_ROW_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> idx == (($past(idx) == IW'(LAT - 1)) ? '0 : $past(idx) + 1'b1)); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_sum)); // R7
  AST_BUSY_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(res_valid && res_ready)) |=> busy); // R2
  AST_TAKEN_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !busy); // R7
endmodule

bind vsum_reduce vsum_reduce_chk #(.LAT(LAT), .W(W), .CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_sum(res_sum), .idx(idx), .rem(rem)
);

// File: tb/sim_vsum_reduce.sv
module sim_vsum_reduce;
  localparam int VEC = 4;
  localparam int LAT = 3;
  localparam int W   = 32;
  localparam int CW  = 16;
  localparam int N   = VEC * LAT;
  localparam int DUE_RUN  = LAT * (N + 1) + 1;
  localparam int DUE_ZERO = N * LAT + 3;

  logic             clk = 0, rst_n = 0, start = 0, in_valid = 0, res_ready = 0;
  logic [CW-1:0]    len = '0;
  logic [VEC*W-1:0] in_data = '0;
  logic             busy, in_ready, res_valid;
  logic [W-1:0]     res_sum;
  int               tests = 0, fails = 0, cyc = 0;
  bit               done = 0;

  vsum_reduce #(.VEC(VEC), .LAT(LAT), .W(W), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_sum(res_sum));

  always #2.5ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic run(int n, int vpct, bit poke);
    logic [W-1:0] exp_sum = '0;
    int sent = 0, last = 0, rejects = 0, guard = 0, hold;
    @(negedge clk);
    start = 1; len = CW'(n);
    @(negedge clk);
    start = 0;
    last = cyc;
    chk("R2 busy after start", busy, 1);
    while (sent < n) begin
      in_valid = ($urandom_range(99) < vpct);
      for (int i = 0; i < VEC; i++) in_data[i*W +: W] = $urandom;
      if (poke && $urandom_range(7) == 0) begin start = 1; len = CW'($urandom_range(60)); end
      else start = 0;
      if (in_valid && in_ready) begin
        for (int i = 0; i < VEC; i++)
          if (sent + i < n) exp_sum += in_data[i*W +: W];
        sent += VEC;
        last = cyc + 1;
      end else if (in_valid) rejects++;
      @(negedge clk);
    end
    start = 0; in_valid = 0;
    if (n > 0) chk("R3 ready drops when count used", in_ready, 0);
    if (vpct == 100) chk("R3 R9 back-to-back beats never refused", rejects, 0);
    while (!res_valid && guard < 1000) begin @(negedge clk); guard++; end
    chk("R8 result latency", cyc - last, (n > 0) ? DUE_RUN : DUE_ZERO);
    chk((n % VEC != 0) ? "R5 R6 sum with partial last beat" : "R6 sum", res_sum, exp_sum);
    hold = $urandom_range(3);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R7 result held", {res_valid, res_sum}, {1'b1, exp_sum});
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    chk("R7 idle after handoff", {busy, res_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy, 0);
    chk("R1 in_ready at reset", in_ready, 0);
    chk("R1 res_valid at reset", res_valid, 0);
    rst_n = 1;
    for (int n = 0; n <= 41; n++) run(n, 100, 0);
    for (int n = 0; n <= 41; n++) run(n, 50, 1);  // R2 stray starts, R4 gaps
    run(997, 70, 1);
    run(400, 25, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule